// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers single-cycle event pulses coming from a display pipeline and latches each one in a raw status register. An enable mask selects which latched events may raise the single interrupt line. Software changes the mask only through two write addresses, one that sets bits and one that clears them. It clears events by writing ones to the masked status register, and it ends each service routine with a write to an end-of-interrupt register.

After the interrupt line rises, it stays high until that end-of-interrupt write. If enabled events are still pending at that point, the line rises again one cycle later. This means an event cannot be lost between the last status clear and the end of the routine.

The register port is a plain 32-bit word-indexed read/write interface. It has no handshake and accepts one access every cycle. A read returns data on `cfg_rdata` one cycle after the read strobe. If a read and a write arrive in the same cycle, the read sees the state from before the write.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset the raw status, the enable mask, `irq_o` and `cfg_rdata` are all zero.
- R2: Implemented event bits are: frame done 0, raster done 1, sync lost 2, AC-bias count 3, FIFO underflow 5, palette loaded 6, end-of-frame 0 at 8, end-of-frame 1 at 9 (implemented mask 0x36F). A pulse on `evt_i[n]` for an implemented bit sets raw status bit n on the next clock, whatever the enable mask holds. The bit then stays set until software clears it.
- R3: Reading word index 0 returns the raw status. Reading index 1 returns raw status ANDed with the enable mask.
- R4: Writing to index 2 sets every enable bit whose data bit is 1 and leaves the others unchanged. Reading index 2 or index 3 returns the enable mask.
- R5: Writing to index 3 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R6: Writing to index 1 clears every raw status bit whose data bit is 1. Writes to index 0 have no effect.
- R7: An event pulse in the same cycle as a clear of the same bit leaves that bit set.
- R8: While `irq_o` is low and no end-of-interrupt write occurs, `irq_o` rises on the clock after any masked status bit is set.
- R9: Once high, `irq_o` stays high until an end-of-interrupt write, even if every masked bit has been cleared.
- R10: A write of any data to index 4 drives `irq_o` low on the next clock. On the clock after that, `irq_o` rises again only if masked bits remain.
- R11: Bits 4, 7 and 10 to 31 always read as zero, and writes and event pulses on them have no effect.
- R12: Read data appears on `cfg_rdata` on the clock after `cfg_rd` and is held until the next read. Index 4 and the unmapped indices 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | One-cycle event pulses, one per bit position |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| irq_o | output | 1 | Interrupt request line |

## Verification
The stimulus first pulses every event position at once, including reserved positions. This shows that latching is independent of the mask and that reserved positions stay empty. It then enables bits one at a time, so that raw and masked reads can be told apart.

Two end-of-interrupt sequences are run: one after the pending bits are cleared and one with a bit still pending. These separate a line that simply drops from a line that rises again. A clear that coincides with an event on the same bit checks which of the two takes priority.

A behavioural model is compared against the interrupt line and read data on every clock. This catches off-by-one-cycle errors that the directed reads alone would miss.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;
  localparam int EVT_W     = 10;
  localparam int REG_IDX_W = 3;

  // Event bit positions (software decodes these)
  localparam int EV_FRAME     = 0;
  localparam int EV_RASTER    = 1;
  localparam int EV_SYNC_LOSS = 2;
  localparam int EV_BIAS_CNT  = 3;
  localparam int EV_UNDERRUN  = 5;
  localparam int EV_PAL_LOAD  = 6;
  localparam int EV_EOF_A     = 8;
  localparam int EV_EOF_B     = 9;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_RAW    = 3'd0,
    REG_MASKED = 3'd1,
    REG_EN_SET = 3'd2,
    REG_EN_CLR = 3'd3,
    REG_EOI    = 3'd4
  } reg_idx_e;

  function automatic logic [EVT_W-1:0] build_impl_mask();
    logic [EVT_W-1:0] m;
    m = '0;
    m[EV_FRAME]     = 1'b1;
    m[EV_RASTER]    = 1'b1;
    m[EV_SYNC_LOSS] = 1'b1;
    m[EV_BIAS_CNT]  = 1'b1;
    m[EV_UNDERRUN]  = 1'b1;
    m[EV_PAL_LOAD]  = 1'b1;
    m[EV_EOF_A]     = 1'b1;
    m[EV_EOF_B]     = 1'b1;
    return m;
  endfunction

  localparam logic [EVT_W-1:0] IMPL_MASK = build_impl_mask();
endpackage

// File: rtl/disp_irq_status.sv
module disp_irq_status
  import disp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] raw_o
);
  logic rsv_unused;
  assign rsv_unused = ^((evt_i | clr_i) & ~IMPL_MASK);

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (evt_i[i]) q <= 1'b1;   // event has priority over clear
        else if (clr_i[i]) q <= 1'b0;
      end
      assign raw_o[i] = q;
    end else begin : g_rsv
      assign raw_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/disp_irq_enable.sv
module disp_irq_enable
  import disp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] set_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] en_o
);
  logic rsv_unused;
  assign rsv_unused = ^((set_i | clr_i) & ~IMPL_MASK);

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= 1'b0;
        else if (set_i[i]) q <= 1'b1;
        else if (clr_i[i]) q <= 1'b0;
      end
      assign en_o[i] = q;
    end else begin : g_rsv
      assign en_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/disp_irq_line.sv
module disp_irq_line (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (eoi_i)  irq_q <= 1'b0;
    else if (!irq_q) irq_q <= pend_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - EVT_W;
  localparam logic [ADDR_W-1:0] A_RAW = ADDR_W'(REG_RAW);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(REG_MASKED);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(REG_EN_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(REG_EN_CLR);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(REG_EOI);

  logic [EVT_W-1:0] wbits, w1c, en_set, en_clr, raw_q, en_q, masked;
  logic             eoi;
  logic             wdata_unused;
  logic [DATA_W-1:0] rd_n, rdata_q;

  assign wbits        = cfg_wdata[EVT_W-1:0];
  assign wdata_unused = ^cfg_wdata[DATA_W-1:EVT_W];

  assign w1c    = (cfg_wr && cfg_addr == A_MSK) ? wbits : '0;
  assign en_set = (cfg_wr && cfg_addr == A_SET) ? wbits : '0;
  assign en_clr = (cfg_wr && cfg_addr == A_CLR) ? wbits : '0;
  assign eoi    = cfg_wr && (cfg_addr == A_EOI);

  disp_irq_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .clr_i (w1c),
    .raw_o (raw_q)
  );

  disp_irq_enable u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en_q)
  );

  assign masked = raw_q & en_q;

  disp_irq_line u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (|masked),
    .eoi_i  (eoi),
    .irq_o  (irq_o)
  );

  always_comb begin
    if (cfg_addr == A_RAW)                          rd_n = {{PAD_W{1'b0}}, raw_q};
    else if (cfg_addr == A_MSK)                     rd_n = {{PAD_W{1'b0}}, masked};
    else if (cfg_addr == A_SET || cfg_addr == A_CLR) rd_n = {{PAD_W{1'b0}}, en_q};
    else                                            rd_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cfg_rd) rdata_q <= rd_n;
  end

  assign cfg_rdata = rdata_q;
endmodule

// File: rtl/disp_irq_ctrl_chk.sv
module disp_irq_ctrl_chk
  import disp_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_W-1:0]  evt_i,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              irq_o,
  input logic [EVT_W-1:0]  raw_q,
  input logic [EVT_W-1:0]  en_q
);
  logic eoi_w, set_w, clr_w;
  logic [EVT_W-1:0] wb, ev;
  assign eoi_w = cfg_wr && cfg_addr == ADDR_W'(REG_EOI);
  assign set_w = cfg_wr && cfg_addr == ADDR_W'(REG_EN_SET);
  assign clr_w = cfg_wr && cfg_addr == ADDR_W'(REG_EN_CLR);
  assign wb    = cfg_wdata[EVT_W-1:0] & IMPL_MASK;
  assign ev    = evt_i & IMPL_MASK;

  p_event_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev != '0 |=> (raw_q & $past(ev)) == $past(ev));

  p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> (en_q & $past(wb)) == $past(wb));

  p_enable_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (en_q & $past(wb)) == '0);

  p_irq_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !eoi_w && (raw_q & en_q) != '0) |=> irq_o);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !eoi_w) |=> irq_o);

  p_eoi_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_w |=> !irq_o);

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[EVT_W-1:0] & ~IMPL_MASK) == '0 && cfg_rdata[DATA_W-1:EVT_W] == '0);
endmodule

bind disp_irq_ctrl disp_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .irq_o     (irq_o),
  .raw_q     (raw_q),
  .en_q      (en_q)
);

// File: tb/disp_irq_ctrl_bench.sv
`timescale 1ns/1ps
module disp_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] IMPL = 32'h0000_036F;

  always #4 clk = ~clk;   // 125 MHz

  disp_irq_ctrl u_disp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [31:0] m_raw = '0, m_en = '0, m_rdata = '0;
  logic        m_irq = 1'b0;

  always @(posedge clk) begin
    logic [31:0] msk;
    if (!rst_n) begin
      m_raw = '0; m_en = '0; m_rdata = '0; m_irq = 1'b0;
    end else begin
      msk = m_raw & m_en;
      if (cfg_rd) begin
        case (cfg_addr)
          3'd0:      m_rdata = m_raw;
          3'd1:      m_rdata = msk;
          3'd2, 3'd3: m_rdata = m_en;
          default:   m_rdata = '0;
        endcase
      end
      if (cfg_wr && cfg_addr == 3'd4) m_irq = 1'b0;
      else if (!m_irq)                m_irq = (msk != 0);
      if (cfg_wr && cfg_addr == 3'd1) m_raw = m_raw & ~cfg_wdata;
      m_raw = (m_raw | {22'd0, evt}) & IMPL;
      if (cfg_wr && cfg_addr == 3'd2) m_en = m_en | cfg_wdata;
      if (cfg_wr && cfg_addr == 3'd3) m_en = m_en & ~cfg_wdata;
      m_en = m_en & IMPL;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq !== m_irq) begin
        fails++;
        $display("FAIL R8 R9 R10 irq per-cycle: actual %0b expected %0b at %0t", irq, m_irq, $time);
      end
      checks++;
      if (cfg_rdata !== m_rdata) begin
        fails++;
        $display("FAIL R12 rdata per-cycle: actual %h expected %h at %0t", cfg_rdata, m_rdata, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd_expect(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd_expect(3'd0, 32'h0, "R1 raw after reset");
    rd_expect(3'd2, 32'h0, "R1 enable after reset");

    // R2 / R11: pulse all positions including reserved ones
    @(negedge clk); evt = 10'h3FF;
    @(negedge clk); evt = '0;
    rd_expect(3'd0, 32'h36F, "R2 R11 raw latch ignores mask and reserved");
    rd_expect(3'd1, 32'h0,   "R3 masked with empty enable");
    chk("R8 no irq without enable", {31'd0, irq}, 32'd0);

    // R6 writes to raw index are ignored
    wr(3'd0, 32'hFFFF_FFFF);
    rd_expect(3'd0, 32'h36F, "R6 raw write ignored");

    // R4 enable set, R8 raise
    wr(3'd2, 32'h5);
    rd_expect(3'd2, 32'h5, "R4 enable set");
    rd_expect(3'd1, 32'h5, "R3 masked view");
    chk("R8 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd2, 32'h100);
    rd_expect(3'd2, 32'h105, "R4 zeros leave enable");
    wr(3'd3, 32'h4);
    rd_expect(3'd3, 32'h101, "R5 enable clear");

    // R6 W1C, R9 hold without EOI
    wr(3'd1, 32'h101);
    rd_expect(3'd0, 32'h26E, "R6 masked write clears");
    rd_expect(3'd1, 32'h0,   "R6 masked now empty");
    chk("R9 irq held until eoi", {31'd0, irq}, 32'd1);

    // R10 EOI with nothing pending
    wr(3'd4, 32'h0);
    chk("R10 irq low after eoi", {31'd0, irq}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R10 irq stays low", {31'd0, irq}, 32'd0);

    // R10 EOI with pending bit -> re-assert
    wr(3'd2, 32'h2);
    repeat (2) @(negedge clk);
    chk("R8 irq raised by enable", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'hDEAD_BEEF);
    chk("R10 irq dropped by eoi", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R10 irq re-asserted", {31'd0, irq}, 32'd1);

    // R7 collision: event wins
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = 3'd1; cfg_wdata = 32'h2; evt = 10'h2;
    @(negedge clk); cfg_wr = 1'b0; cfg_wdata = '0; evt = '0;
    rd_expect(3'd0, 32'h26E, "R7 event beats clear");
    wr(3'd1, 32'h8);
    rd_expect(3'd0, 32'h266, "R6 single bit clear");

    // R11 reserved enable bits
    wr(3'd2, 32'hFFFF_FFFF);
    rd_expect(3'd2, 32'h36F, "R11 enable reserved read zero");
    rd_expect(3'd1, 32'h266, "R3 masked after full enable");

    // R12 zero-reading indices, unmapped write has no effect
    rd_expect(3'd4, 32'h0, "R12 eoi reads zero");
    wr(3'd5, 32'hFFFF_FFFF);
    rd_expect(3'd7, 32'h0, "R12 unmapped reads zero");
    rd_expect(3'd0, 32'h266, "R12 raw unchanged by unmapped write");
    repeat (3) @(negedge clk);
    chk("R12 rdata held without read", cfg_rdata, 32'h266);

    summary();
  end
endmodule